// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a bank of external input lines and turns activity on them into pending events that firmware can see and clear. Each line is set up on its own as edge- or level-sensitive, with an active polarity, an interrupt mask and an enable for the local processor domain. A software trigger per line lets firmware raise an event without any pin activity. All pending, unmasked and enabled events are combined into a single interrupt output.

Lines are packed 32 to a register word. Line n lives in word n/32 at bit n%32. Control state is reached through a plain synchronous read/write port. Mask, sense, polarity and soft-trigger state each have a read-only view and two write aliases: a write-1-to-set alias and a write-1-to-clear alias. Firmware normally enables the domain first, then sets sense and polarity, then unmasks the line through the clear alias. It services an event by reading status and writing a 1 to the acknowledge word.

Top module: `xline_irq_ctrl`

## Requirements
- R1: Line n maps to word n/32, bit n%32. The default of 224 lines uses words 0 to 6. Each bank is a 64-byte window at byte offset 64*b, and word k of a bank sits at +4k. The bank index b is ordered: 0 status, 1 acknowledge, 2 mask, 3 mask-set, 4 mask-clear, 5 sense, 6 sense-set, 7 sense-clear, 8 soft, 9 soft-set, 10 soft-clear, 11 reserved, 12 polarity, 13 polarity-set, 14 polarity-clear, 15 reserved.
- R2: After reset every mask bit is 1. Status, sense, polarity, soft and enable bits are 0, and the interrupt output is 0.
- R3: A 1 written to a set alias sets the bit, and a 1 written to a clear alias clears it. Written 0 bits change nothing. Writes to the plain mask, sense, soft, polarity and status words are ignored.
- R4: A sense bit of 0 selects edge detection. Polarity 1 then means a rising edge and polarity 0 a falling edge. A detected edge sets status, which stays 1 until acknowledged.
- R5: A sense bit of 1 selects level detection. Polarity 1 means active high and polarity 0 active low. While the level is active, status is set again on the edge after an acknowledge.
- R6: Writing 1 to a bit of an acknowledge word clears that status bit on the write edge. The acknowledge takes priority over an event in that same cycle.
- R7: A soft bit of 1 acts as an event on its line, so status is set on the clock edge after the soft bit is set.
- R8: Domain enable word k is at byte 0x400+4k and is written and read directly. The interrupt output is the OR of all status bits whose mask bit is 0 and whose enable bit is 1.
- R9: Reads of the acknowledge bank, the set and clear aliases, the reserved banks, bank words 7 to 15, and the range from 0x41C upward (including the other-domain words at 0x420) return zero.
- R10: A read presents its data on bus_rdata on the clock edge that samples bus_rd. bus_rdata holds its value while no read is issued.
- R11: Each line passes through a two-flop synchronizer. A line change set up before clock edge E0 sets status at edge E2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lines_in | input | NUM_LINES | Raw external input lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Each result has a fixed cycle at which it is due:
- A pin change is seen in status on the third rising edge after it is applied.
- An alias write or acknowledge takes effect on the edge that samples it.
- A soft trigger reaches status one edge after the write.
- A level that is still active sets status again one edge after its acknowledge.

The bench applies all inputs on falling edges and samples outputs on falling edges. It counts the exact number of falling edges to each result, and checks that a result is absent one edge early where the timing matters. Register reads are sampled on the falling edge that follows the sampling rising edge.

// File: rtl/xl_pkg.sv
package xl_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WIDX_W = 4;

  typedef enum logic [3:0] {
    BK_STATUS   = 4'd0,
    BK_ACK      = 4'd1,
    BK_MASK     = 4'd2,
    BK_MASK_SET = 4'd3,
    BK_MASK_CLR = 4'd4,
    BK_SENSE    = 4'd5,
    BK_SENS_SET = 4'd6,
    BK_SENS_CLR = 4'd7,
    BK_SOFT     = 4'd8,
    BK_SOFT_SET = 4'd9,
    BK_SOFT_CLR = 4'd10,
    BK_RSV0     = 4'd11,
    BK_POL      = 4'd12,
    BK_POL_SET  = 4'd13,
    BK_POL_CLR  = 4'd14,
    BK_RSV1     = 4'd15
  } bank_e;
endpackage

// File: rtl/xl_setclr_reg.sv
module xl_setclr_reg import xl_pkg::*; #(
  parameter int unsigned NWORDS    = 7,
  parameter logic        RESET_BIT = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      set_en,
  input  logic                      clr_en,
  input  logic [WIDX_W-1:0]         widx,
  input  logic [BUS_W-1:0]          wdata,
  output logic [NWORDS*BUS_W-1:0]   q
);
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q[w*BUS_W +: BUS_W] <= {BUS_W{RESET_BIT}};
      end else if (widx == WIDX_W'(w)) begin
        if (set_en)      q[w*BUS_W +: BUS_W] <= q[w*BUS_W +: BUS_W] | wdata;
        else if (clr_en) q[w*BUS_W +: BUS_W] <= q[w*BUS_W +: BUS_W] & ~wdata;
      end
    end
  end
endmodule

// File: rtl/xl_line_detect.sv
module xl_line_detect #(
  parameter int unsigned WIDTH = 224
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lines,
  input  logic [WIDTH-1:0] sense,
  input  logic [WIDTH-1:0] pol,
  output logic [WIDTH-1:0] hit
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;
  logic [WIDTH-1:0] rise, fall, lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= lines;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    rise = sync_q & ~prev_q;
    fall = ~sync_q & prev_q;
    lvl  = ~(sync_q ^ pol);
    hit  = (sense & lvl) | (~sense & ((pol & rise) | (~pol & fall)));
  end
endmodule

// File: rtl/xline_irq_ctrl.sv
module xline_irq_ctrl import xl_pkg::*; #(
  parameter int unsigned NUM_LINES = 224
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_in,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic                 irq_out
);
  localparam int unsigned NWORDS = (NUM_LINES + BUS_W - 1) / BUS_W;
  localparam int unsigned PADW   = NWORDS * BUS_W;

  logic [PADW-1:0] lines_pad, mask_q, sense_q, pol_q, soft_q, en_q, status_q, hit;
  logic [WIDX_W-1:0] widx, en_idx;
  bank_e bank;
  logic in_banks, word_ok, bank_wr, en_hit;
  logic [BUS_W-1:0] rd_word;

  always_comb begin
    lines_pad = '0;
    lines_pad[NUM_LINES-1:0] = lines_in;
  end

  // address decode
  assign in_banks = (bus_addr[11:10] == 2'b00);
  assign bank     = bank_e'(bus_addr[9:6]);
  assign widx     = bus_addr[5:2];
  assign word_ok  = (widx < WIDX_W'(NWORDS));
  assign bank_wr  = bus_wr && in_banks && word_ok;
  assign en_idx   = {1'b0, bus_addr[4:2]};
  assign en_hit   = (bus_addr[11:5] == 7'b0100000) && (en_idx < WIDX_W'(NWORDS));

  xl_setclr_reg #(.NWORDS(NWORDS), .RESET_BIT(1'b1)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_en(bank_wr && bank == BK_MASK_SET), .clr_en(bank_wr && bank == BK_MASK_CLR),
    .widx(widx), .wdata(bus_wdata), .q(mask_q));

  xl_setclr_reg #(.NWORDS(NWORDS), .RESET_BIT(1'b0)) u_sense (
    .clk(clk), .rst_n(rst_n),
    .set_en(bank_wr && bank == BK_SENS_SET), .clr_en(bank_wr && bank == BK_SENS_CLR),
    .widx(widx), .wdata(bus_wdata), .q(sense_q));

  xl_setclr_reg #(.NWORDS(NWORDS), .RESET_BIT(1'b0)) u_pol (
    .clk(clk), .rst_n(rst_n),
    .set_en(bank_wr && bank == BK_POL_SET), .clr_en(bank_wr && bank == BK_POL_CLR),
    .widx(widx), .wdata(bus_wdata), .q(pol_q));

  xl_setclr_reg #(.NWORDS(NWORDS), .RESET_BIT(1'b0)) u_soft (
    .clk(clk), .rst_n(rst_n),
    .set_en(bank_wr && bank == BK_SOFT_SET), .clr_en(bank_wr && bank == BK_SOFT_CLR),
    .widx(widx), .wdata(bus_wdata), .q(soft_q));

  xl_line_detect #(.WIDTH(PADW)) u_detect (
    .clk(clk), .rst_n(rst_n), .lines(lines_pad),
    .sense(sense_q), .pol(pol_q), .hit(hit));

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [BUS_W-1:0] ack_w;
    assign ack_w = (bank_wr && bank == BK_ACK && widx == WIDX_W'(w)) ? bus_wdata : '0;

    // status: acknowledge wins over a same-cycle event
    always_ff @(posedge clk) begin
      if (!rst_n) status_q[w*BUS_W +: BUS_W] <= '0;
      else status_q[w*BUS_W +: BUS_W] <=
             (status_q[w*BUS_W +: BUS_W] | hit[w*BUS_W +: BUS_W] | soft_q[w*BUS_W +: BUS_W]) & ~ack_w;
    end

    // domain enable: plain read/write word
    always_ff @(posedge clk) begin
      if (!rst_n) en_q[w*BUS_W +: BUS_W] <= '0;
      else if (bus_wr && en_hit && en_idx == WIDX_W'(w)) en_q[w*BUS_W +: BUS_W] <= bus_wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (in_banks && widx == WIDX_W'(w)) begin
        case (bank)
          BK_STATUS: rd_word = status_q[w*BUS_W +: BUS_W];
          BK_MASK:   rd_word = mask_q[w*BUS_W +: BUS_W];
          BK_SENSE:  rd_word = sense_q[w*BUS_W +: BUS_W];
          BK_SOFT:   rd_word = soft_q[w*BUS_W +: BUS_W];
          BK_POL:    rd_word = pol_q[w*BUS_W +: BUS_W];
          default:   rd_word = '0;
        endcase
      end else if (en_hit && en_idx == WIDX_W'(w)) begin
        rd_word = en_q[w*BUS_W +: BUS_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  assign irq_out = |(status_q[NUM_LINES-1:0] & ~mask_q[NUM_LINES-1:0] & en_q[NUM_LINES-1:0]);
endmodule

// File: rtl/xl_irq_ctrl_chk.sv
module xl_irq_ctrl_chk #(
  parameter int unsigned PADW = 224
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [11:0]     bus_addr,
  input logic            wdata0,
  input logic [31:0]     bus_rdata,
  input logic            irq_out,
  input logic [PADW-1:0] status_q,
  input logic [PADW-1:0] mask_q,
  input logic            sense0,
  input logic            soft0
);
  logic ack0;
  assign ack0 = bus_wr && (bus_addr == 12'h040) && wdata0;

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack0 |=> !status_q[0]);

  assert_edge_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[0] && !sense0 && !ack0) |=> status_q[0]);

  assert_soft_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (soft0 && !ack0) |=> status_q[0]);

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_out);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|status_q) |-> !irq_out);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind xline_irq_ctrl xl_irq_ctrl_chk #(.PADW(PADW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .wdata0(bus_wdata[0]), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .status_q(status_q), .mask_q(mask_q),
  .sense0(sense_q[0]), .soft0(soft_q[0]));

// File: tb/xline_irq_ctrl_tb.sv
module xline_irq_ctrl_tb;
  localparam int NL = 224;
  localparam logic [11:0] A_STAT = 12'h000, A_ACK = 12'h040, A_MASK = 12'h080,
    A_MSET = 12'h0C0, A_MCLR = 12'h100, A_SENS = 12'h140, A_SSET = 12'h180,
    A_SCLR = 12'h1C0, A_SOFT = 12'h200, A_FSET = 12'h240, A_FCLR = 12'h280,
    A_RSV = 12'h2C0, A_POL = 12'h300, A_PSET = 12'h340, A_EN = 12'h400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rv;
  logic irq_out;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  xline_irq_ctrl #(.NUM_LINES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .lines_in(lines), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic t_reset;
    rd(A_MASK, rv);        chk("R2 mask w0", rv, 32'hFFFF_FFFF);
    rd(A_MASK + 12'd24, rv); chk("R2 mask w6", rv, 32'hFFFF_FFFF);
    rd(A_STAT, rv);        chk("R2 status w0", rv, 0);
    rd(A_SENS + 12'd12, rv); chk("R2 sense w3", rv, 0);
    rd(A_EN, rv);          chk("R2 enable w0", rv, 0);
    chk("R2 irq", irq_out, 0);
  endtask

  task automatic t_alias;
    wr(A_SSET + 12'd20, 32'h0000_00F0);
    rd(A_SENS + 12'd20, rv); chk("R3 set alias", rv, 32'h0000_00F0);
    wr(A_SCLR + 12'd20, 32'h0000_0030);
    rd(A_SENS + 12'd20, rv); chk("R3 clear alias", rv, 32'h0000_00C0);
    wr(A_SENS + 12'd20, 32'hFFFF_FFFF);
    rd(A_SENS + 12'd20, rv); chk("R3 plain write ignored", rv, 32'h0000_00C0);
    wr(A_SCLR + 12'd20, 32'h0000_00C0);
  endtask

  task automatic t_edge;
    wr(A_EN + 12'd4, 32'h6);
    wr(A_PSET + 12'd4, 32'h2);       // line 33 rising, line 34 falling
    wr(A_MCLR + 12'd4, 32'h6);
    lines[33] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 not before third edge", irq_out, 0);
    @(negedge clk);
    chk("R11 R4 rising edge irq", irq_out, 1);
    lines[33] = 1'b0;
    repeat (4) @(negedge clk);
    rd(A_STAT + 12'd4, rv); chk("R4 latched after line drops", rv, 32'h2);
    wr(A_ACK + 12'd4, 32'h2);
    chk("R6 ack clears", irq_out, 0);
    lines[34] = 1'b1;
    repeat (4) @(negedge clk);
    rd(A_STAT + 12'd4, rv); chk("R4 rise ignored on falling line", rv, 0);
    lines[34] = 1'b0;
    repeat (3) @(negedge clk);
    rd(A_STAT + 12'd4, rv); chk("R4 R1 falling edge line34 word1 bit2", rv, 32'h4);
    wr(A_ACK + 12'd4, 32'h0);
    rd(A_STAT + 12'd4, rv); chk("R6 zero ack bits no effect", rv, 32'h4);
    wr(A_ACK + 12'd4, 32'h4);
  endtask

  task automatic t_level;
    wr(A_EN + 12'd8, 32'h3);
    wr(A_PSET + 12'd8, 32'h1);       // line 64 high, line 65 low
    wr(A_MCLR + 12'd8, 32'h3);
    wr(A_SSET + 12'd8, 32'h1);
    lines[64] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 level high irq", irq_out, 1);
    wr(A_ACK + 12'd8, 32'h1);
    chk("R6 ack wins over level", irq_out, 0);
    @(negedge clk);
    chk("R5 level re-sets after ack", irq_out, 1);
    lines[64] = 1'b0;
    repeat (3) @(negedge clk);
    wr(A_ACK + 12'd8, 32'h1);
    @(negedge clk);
    rd(A_STAT + 12'd8, rv); chk("R5 inactive level stays clear", rv, 0);
    wr(A_SSET + 12'd8, 32'h2);
    @(negedge clk);
    rd(A_STAT + 12'd8, rv); chk("R5 level low fires", rv, 32'h2);
    lines[65] = 1'b1;
    repeat (3) @(negedge clk);
    wr(A_ACK + 12'd8, 32'h2);
    @(negedge clk);
    rd(A_STAT + 12'd8, rv); chk("R5 level low released", rv, 0);
  endtask

  task automatic t_soft_gate;
    wr(A_EN + 12'd24, 32'h100);
    wr(A_MCLR + 12'd24, 32'h100);
    wr(A_FSET + 12'd24, 32'h100);
    chk("R7 soft not same edge", irq_out, 0);
    @(negedge clk);
    chk("R7 soft fires line200", irq_out, 1);
    rd(A_SOFT + 12'd24, rv); chk("R7 soft readback", rv, 32'h100);
    wr(A_FCLR + 12'd24, 32'h100);
    rd(A_STAT + 12'd24, rv); chk("R1 line200 word6 bit8", rv, 32'h100);
    wr(A_MSET + 12'd24, 32'h100);
    chk("R8 masked quiet", irq_out, 0);
    wr(A_MCLR + 12'd24, 32'h100);
    wr(A_EN + 12'd24, 32'h0);
    chk("R8 disabled quiet", irq_out, 0);
    wr(A_EN + 12'd24, 32'h100);
    chk("R8 enabled irq", irq_out, 1);
    rd(A_EN + 12'd24, rv); chk("R8 enable readback", rv, 32'h100);
    wr(A_ACK + 12'd24, 32'h100);
    chk("R6 soft ack", irq_out, 0);
  endtask

  task automatic t_zero_reads;
    rd(A_ACK, rv);          chk("R9 ack bank", rv, 0);
    rd(A_MSET, rv);         chk("R9 mask-set alias", rv, 0);
    rd(A_PSET + 12'd8, rv); chk("R9 pol-set alias", rv, 0);
    rd(A_RSV, rv);          chk("R9 reserved bank", rv, 0);
    rd(A_MASK + 12'd28, rv); chk("R9 word 7", rv, 0);
    rd(12'h420, rv);        chk("R9 other domain", rv, 0);
    rd(A_POL + 12'd8, rv);  chk("R1 polarity word2", rv, 32'h1);
  endtask

  task automatic t_hold;
    rd(A_MASK, rv);
    repeat (3) @(negedge clk);
    chk("R10 rdata holds", bus_rdata, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_alias();
    t_edge();
    t_level();
    t_soft_gate();
    t_zero_reads();
    t_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule